// File: doc/BRIEF.md
# Indirect Register Access Bridge

This block lets a host reach a 32-bit internal bus through four 64-bit indirect registers. The host side is a plain register port that completes every access in one cycle. Writing a command word to the control register starts exactly one read or write on the internal bus. The command word carries the direction, the access size and the 32-bit target address. A write takes its payload from the data register.

The internal side is a request/acknowledge bus with an error flag. The bridge keeps one transaction in flight at a time and holds the request steady until it is acknowledged. If no acknowledge arrives within a fixed number of cycles, the attempt counts as a bus error. When the transaction ends, the outcome is packed into a status word. For a read, that word holds the returned data. The status word clears when the host reads it, so software polls status until the done flag appears, and that same read consumes the result.

Top module: `ireg_bridge`

## Requirements
- R1: Host address bits [4:3] pick the register (0 control, 1 reset, 2 status, 3 data) and bits [2:0] are ignored. An access with `hst_dword` low has no effect and reads as zero.
- R2: A control write with no transaction in flight raises `bus_req` in the next cycle. In that request, `bus_addr` is command bits [31:0], `bus_size` is command bits [59:56], and `bus_we` is the inverse of command bit 48 (bit 48 set means read).
- R3: While `bus_req` is high and no acknowledge has arrived, `bus_req`, `bus_addr`, `bus_size`, `bus_we` and `bus_wdata` stay unchanged. `bus_req` drops in the cycle after an acknowledge.
- R4: A read acknowledged without error leaves status equal to the done flag (bit 11) ORed with the 32-bit read data in bits [57:26].
- R5: A read that ends with `bus_err` or a timeout leaves status equal to the done flag with all ones in bits [57:26].
- R6: A write drives the data register on `bus_wdata`, with the lowest-address byte in bits [31:24]. On completion, status becomes 0x800 whether or not an error is reported.
- R7: A host write to the data register keeps bits [63:32] of the written value. A read of the data register returns that value in bits [63:32] and zeros below.
- R8: A status read returns the current value and clears status to zero. A completion in the same cycle as the read takes priority over the clear.
- R9: Control and reset registers read as zero. Writes to the reset and status registers change nothing.
- R10: A control write while a transaction is in flight is ignored. Status is cleared at launch and reads zero until the transaction ends.
- R11: A request that sees no acknowledge for TIMEOUT_CYCLES (256) cycles ends as an error, and `bus_req` drops. An acknowledge in the last allowed cycle still succeeds.
- R12: After reset, `bus_req` is low, status is zero and the data register is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hst_valid | input | 1 | Host access in this cycle |
| hst_write | input | 1 | 1 = host write, 0 = host read |
| hst_dword | input | 1 | Access is a full 64-bit word |
| hst_addr | input | 5 | Host byte address; bits [4:3] select the register |
| hst_wdata | input | 64 | Host write value |
| hst_rdata | output | 64 | Host read value, valid in the access cycle |
| bus_req | output | 1 | Internal bus request |
| bus_we | output | 1 | 1 = bus write |
| bus_addr | output | 32 | Bus target address |
| bus_size | output | 4 | Access size in bytes |
| bus_wdata | output | 32 | Bus write payload, lowest-address byte in [31:24] |
| bus_ack | input | 1 | Target acknowledge |
| bus_err | input | 1 | Error flag, qualified by bus_ack |
| bus_rdata | input | 32 | Read data, qualified by bus_ack |

## Verification
Two pairs of events can land in the same cycle: a host status read and a bus acknowledge, and a host control write and a transaction already in flight. The bench drives a status read in the cycle the acknowledge is presented. It expects that read to return zero and the next read to return the completed word. It also issues a second control write while a request is pending and expects the pending address to stay in place with no second request afterwards. Random transactions with random delays, errors and data are checked against status words computed by bench functions.

// File: rtl/ib_pkg.sv
package ib_pkg;
    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_RST  = 2'd1,
        SEL_STAT = 2'd2,
        SEL_DATA = 2'd3
    } ib_sel_e;

    localparam int CMD_RD_BIT  = 48;
    localparam int CMD_SZ_LO   = 56;
    localparam int DONE_BIT    = 11;
    localparam int RDF_LO      = 26;
    localparam logic [63:0] STAT_DONE = 64'd1 << DONE_BIT;

    typedef struct packed {
        logic        we;
        logic [3:0]  size;
        logic [31:0] addr;
        logic [31:0] wdata;
    } ib_cmd_t;

    function automatic logic [63:0] ib_stat_word(input logic we, input logic fail,
                                                 input logic [31:0] rd);
        logic [31:0] field;
        field = fail ? 32'hFFFF_FFFF : rd;
        if (we) return STAT_DONE;
        return STAT_DONE | ({32'd0, field} << RDF_LO);
    endfunction
endpackage

// File: rtl/ib_bus_engine.sv
module ib_bus_engine
    import ib_pkg::*;
#(
    parameter int TIMEOUT_CYCLES = 256
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  ib_cmd_t     cmd,
    input  logic        bus_ack,
    input  logic        bus_err,
    output logic        busy,
    output logic        fin,
    output logic        fin_fail,
    output logic        fin_we,
    output logic        bus_req,
    output logic        bus_we,
    output logic [31:0] bus_addr,
    output logic [3:0]  bus_size,
    output logic [31:0] bus_wdata
);
    localparam int TW = $clog2(TIMEOUT_CYCLES + 1);
    localparam logic [TW-1:0] LAST = TW'(TIMEOUT_CYCLES - 1);

    typedef struct packed {
        logic          busy;
        ib_cmd_t       cmd;
        logic [TW-1:0] timer;
    } eng_t;

    eng_t eng_d, eng_q;
    logic expire;

    always_comb begin
        eng_d    = eng_q;
        expire   = eng_q.busy && !bus_ack && (eng_q.timer == LAST);
        fin      = eng_q.busy && (bus_ack || expire);
        fin_fail = expire || bus_err;
        fin_we   = eng_q.cmd.we;
        if (!eng_q.busy) begin
            if (start) begin
                eng_d.busy  = 1'b1;
                eng_d.cmd   = cmd;
                eng_d.timer = '0;
            end
        end else if (fin) begin
            eng_d.busy = 1'b0;
        end else begin
            eng_d.timer = eng_q.timer + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) eng_q <= '0;
        else        eng_q <= eng_d;
    end

    assign busy      = eng_q.busy;
    assign bus_req   = eng_q.busy;
    assign bus_we    = eng_q.cmd.we;
    assign bus_addr  = eng_q.cmd.addr;
    assign bus_size  = eng_q.cmd.size;
    assign bus_wdata = eng_q.cmd.wdata;

    assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack && !expire) |=> (bus_req && $stable(bus_addr) &&
            $stable(bus_wdata) && $stable(bus_size) && $stable(bus_we)));

    assert_req_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_ack) |=> !bus_req);

    assert_timer_fresh_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_req) |-> (eng_q.timer == '0));
endmodule

// File: rtl/ib_host_regs.sv
module ib_host_regs
    import ib_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        hst_valid,
    input  logic        hst_write,
    input  logic        hst_dword,
    input  logic [1:0]  hst_sel,
    input  logic [63:0] hst_wdata,
    output logic [63:0] hst_rdata,
    input  logic        busy,
    input  logic        fin,
    input  logic        fin_fail,
    input  logic        fin_we,
    input  logic [31:0] fin_rdata,
    output logic        launch,
    output ib_cmd_t     cmd
);
    typedef struct packed {
        logic [31:0] data;
        logic [63:0] stat;
    } regs_t;

    regs_t   regs_d, regs_q;
    ib_sel_e sel;
    logic    acc, rd_stat;
    logic [63:0] unused_cmd_bits;

    always_comb begin
        sel     = ib_sel_e'(hst_sel);
        acc     = hst_valid && hst_dword;
        launch  = acc && hst_write && (sel == SEL_CTRL) && !busy;
        rd_stat = acc && !hst_write && (sel == SEL_STAT);

        cmd.we    = !hst_wdata[CMD_RD_BIT];
        cmd.size  = hst_wdata[CMD_SZ_LO +: 4];
        cmd.addr  = hst_wdata[31:0];
        cmd.wdata = regs_q.data;
        unused_cmd_bits = hst_wdata;

        regs_d = regs_q;
        if (acc && hst_write && (sel == SEL_DATA)) regs_d.data = hst_wdata[63:32];
        if (fin)          regs_d.stat = ib_stat_word(fin_we, fin_fail, fin_rdata);
        else if (launch)  regs_d.stat = '0;
        else if (rd_stat) regs_d.stat = '0;

        hst_rdata = '0;
        if (acc && !hst_write) begin
            case (sel)
                SEL_STAT: hst_rdata = regs_q.stat;
                SEL_DATA: hst_rdata = {regs_q.data, 32'd0};
                default:  hst_rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assert_stat_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stat && !fin) |=> (regs_q.stat == '0));

    assert_stat_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fin |=> regs_q.stat[DONE_BIT]);

    assert_busy_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !fin) |-> (regs_q.stat == '0));
endmodule

// File: rtl/ireg_bridge.sv
module ireg_bridge
    import ib_pkg::*;
#(
    parameter int TIMEOUT_CYCLES = 256
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        hst_valid,
    input  logic        hst_write,
    input  logic        hst_dword,
    input  logic [4:0]  hst_addr,
    input  logic [63:0] hst_wdata,
    output logic [63:0] hst_rdata,
    output logic        bus_req,
    output logic        bus_we,
    output logic [31:0] bus_addr,
    output logic [3:0]  bus_size,
    output logic [31:0] bus_wdata,
    input  logic        bus_ack,
    input  logic        bus_err,
    input  logic [31:0] bus_rdata
);
    logic    launch, busy, fin, fin_fail, fin_we;
    ib_cmd_t cmd;
    logic [2:0] unused_low_addr;

    assign unused_low_addr = hst_addr[2:0];

    ib_host_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .hst_valid (hst_valid),
        .hst_write (hst_write),
        .hst_dword (hst_dword),
        .hst_sel   (hst_addr[4:3]),
        .hst_wdata (hst_wdata),
        .hst_rdata (hst_rdata),
        .busy      (busy),
        .fin       (fin),
        .fin_fail  (fin_fail),
        .fin_we    (fin_we),
        .fin_rdata (bus_rdata),
        .launch    (launch),
        .cmd       (cmd)
    );

    ib_bus_engine #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (launch),
        .cmd       (cmd),
        .bus_ack   (bus_ack),
        .bus_err   (bus_err),
        .busy      (busy),
        .fin       (fin),
        .fin_fail  (fin_fail),
        .fin_we    (fin_we),
        .bus_req   (bus_req),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_size  (bus_size),
        .bus_wdata (bus_wdata)
    );

    assert_launch_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (hst_valid && hst_write && hst_dword && hst_addr[4:3] == 2'd0 && !bus_req)
        |=> (bus_req && bus_addr == $past(hst_wdata[31:0]) &&
             bus_we == !$past(hst_wdata[CMD_RD_BIT])));

    assert_busy_ignore_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (hst_valid && hst_write && hst_dword && hst_addr[4:3] == 2'd0 && bus_req)
        |=> ($stable(bus_addr) && $stable(bus_we) && $stable(bus_size)));
endmodule

// File: tb/test_ireg_bridge.sv
`timescale 1ns/1ps
module test_ireg_bridge;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hv = 1'b0, hw = 1'b0, hdw = 1'b0;
    logic [4:0]  ha = '0;
    logic [63:0] hwd = '0;
    logic [63:0] hrd;
    logic        bus_req, bus_we;
    logic [31:0] bus_addr, bus_wdata;
    logic [3:0]  bus_size;
    logic        ack = 1'b0, err = 1'b0;
    logic [31:0] brd = '0;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    ireg_bridge i_ireg_bridge (
        .clk(clk), .rst_n(rst_n),
        .hst_valid(hv), .hst_write(hw), .hst_dword(hdw), .hst_addr(ha),
        .hst_wdata(hwd), .hst_rdata(hrd),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_size(bus_size), .bus_wdata(bus_wdata),
        .bus_ack(ack), .bus_err(err), .bus_rdata(brd)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] exp_stat(input bit rd, input bit fail, input logic [31:0] d);
        if (!rd) return 64'h800;
        return 64'h800 | ({32'd0, (fail ? 32'hFFFF_FFFF : d)} << 26);
    endfunction

    function automatic logic [63:0] mk_cmd(input bit rd, input logic [3:0] sz, input logic [31:0] a);
        return {4'h0, sz, 7'd0, rd, 16'd0, a};
    endfunction

    // one host access: starts right after a falling edge, ends at the next one
    task automatic hop(input bit wr, input logic [1:0] sel, input logic [63:0] wd,
                       input bit dw, output logic [63:0] rd);
        hv = 1'b1; hw = wr; hdw = dw; hwd = wd;
        ha = {sel, 3'($urandom)};
        #1 rd = hrd;
        @(negedge clk);
        hv = 1'b0; hw = 1'b0; hdw = 1'b0;
    endtask

    task automatic txn(input bit rd, input logic [31:0] a, input logic [3:0] sz,
                       input logic [31:0] dreg, input int dly, input bit tmo,
                       input bit e, input logic [31:0] d);
        logic [63:0] r;
        bit fail;
        hop(1, 2'd0, mk_cmd(rd, sz, a), 1, r);
        check("R2 req", {63'd0, bus_req}, 64'd1);
        check("R2 addr", {32'd0, bus_addr}, {32'd0, a});
        check("R2 size", {60'd0, bus_size}, {60'd0, sz});
        check("R2 dir", {63'd0, bus_we}, {63'd0, !rd});
        if (!rd) check("R6 wdata", {32'd0, bus_wdata}, {32'd0, dreg});
        if (tmo) begin
            repeat (255) @(negedge clk);
            check("R11 still pending", {63'd0, bus_req}, 64'd1);
            @(negedge clk);
            check("R11 dropped", {63'd0, bus_req}, 64'd0);
            fail = 1;
        end else begin
            repeat (dly) @(negedge clk);
            check("R3 held", {31'd0, bus_req, bus_addr}, {31'd0, 1'b1, a});
            ack = 1'b1; err = e; brd = d;
            @(negedge clk);
            ack = 1'b0; err = 1'b0; brd = 32'($urandom);
            check("R3 drop", {63'd0, bus_req}, 64'd0);
            fail = e;
        end
        hop(0, 2'd2, 64'd0, 1, r);
        check(rd ? (fail ? "R5 status" : "R4 status") : "R6 status", r, exp_stat(rd, fail, d));
        hop(0, 2'd2, 64'd0, 1, r);
        check("R8 cleared", r, 64'd0);
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [63:0] r;
        logic [31:0] dreg;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        check("R12 req", {63'd0, bus_req}, 64'd0);
        hop(0, 2'd2, 64'd0, 1, r); check("R12 status", r, 64'd0);
        hop(0, 2'd3, 64'd0, 1, r); check("R12 data", r, 64'd0);

        // R7 data register
        hop(1, 2'd3, 64'hAAAA_BBBB_CCCC_DDDD, 1, r);
        hop(0, 2'd3, 64'd0, 1, r); check("R7 data", r, 64'hAAAA_BBBB_0000_0000);
        dreg = 32'hAAAA_BBBB;

        // R1 partial accesses
        hop(1, 2'd3, 64'h1111_2222_3333_4444, 0, r);
        hop(0, 2'd3, 64'd0, 1, r); check("R1 partial write", r, 64'hAAAA_BBBB_0000_0000);
        hop(0, 2'd3, 64'd0, 0, r); check("R1 partial read", r, 64'd0);

        // R9 control and reset read as zero
        hop(0, 2'd0, 64'd0, 1, r); check("R9 ctrl read", r, 64'd0);
        hop(0, 2'd1, 64'd0, 1, r); check("R9 reset read", r, 64'd0);

        // directed transactions
        txn(1, 32'hD001_0060, 4'd4, dreg, 0, 0, 0, 32'h1234_5678);
        txn(1, 32'hE000_0000, 4'd1, dreg, 3, 0, 1, 32'h0);
        txn(0, 32'hF000_0010, 4'd4, dreg, 2, 0, 1, 32'h0);
        txn(1, 32'hC001_2000, 4'd2, dreg, 255, 0, 0, 32'hCAFE_F00D);
        txn(1, 32'h0000_0100, 4'd4, dreg, 0, 1, 0, 32'h0);
        txn(0, 32'h0000_0200, 4'd4, dreg, 0, 1, 0, 32'h0);

        // R9 writes to status and reset change nothing
        txn(1, 32'h0000_0004, 4'd4, dreg, 1, 0, 0, 32'h8000_0001);
        hop(1, 2'd0, mk_cmd(1, 4'd4, 32'h40), 1, r);
        ack = 1'b1; brd = 32'h0F0F_0F0F;
        @(negedge clk); ack = 1'b0;
        hop(1, 2'd2, 64'hFFFF_FFFF_FFFF_FFFF, 1, r);
        hop(1, 2'd1, 64'hFFFF_FFFF_FFFF_FFFF, 1, r);
        hop(0, 2'd2, 64'd0, 1, r); check("R9 status write ignored", r, exp_stat(1, 0, 32'h0F0F_0F0F));
        hop(0, 2'd3, 64'd0, 1, r); check("R9 reset write ignored", r, {dreg, 32'd0});

        // R8 status read in the same cycle as the acknowledge
        hop(1, 2'd0, mk_cmd(1, 4'd4, 32'h80), 1, r);
        ack = 1'b1; brd = 32'h5A5A_A5A5;
        hop(0, 2'd2, 64'd0, 1, r);
        ack = 1'b0;
        check("R8 same-cycle read", r, 64'd0);
        hop(0, 2'd2, 64'd0, 1, r); check("R8 completion wins", r, exp_stat(1, 0, 32'h5A5A_A5A5));

        // R10 control write while busy
        hop(1, 2'd0, mk_cmd(0, 4'd4, 32'h0000_1000), 1, r);
        hop(1, 2'd0, mk_cmd(1, 4'd2, 32'h0000_2000), 1, r);
        check("R10 addr kept", {32'd0, bus_addr}, 64'h1000);
        check("R10 dir kept", {63'd0, bus_we}, 64'd1);
        hop(0, 2'd2, 64'd0, 1, r); check("R10 status while busy", r, 64'd0);
        ack = 1'b1;
        @(negedge clk); ack = 1'b0;
        check("R10 no second request", {63'd0, bus_req}, 64'd0);
        hop(0, 2'd2, 64'd0, 1, r); check("R10 write done", r, 64'h800);

        // random transactions
        for (int i = 0; i < 40; i++) begin
            bit rd_i = 1'($urandom);
            if ($urandom % 3 == 0) begin
                logic [63:0] v = {$urandom, $urandom};
                hop(1, 2'd3, v, 1, r);
                dreg = v[63:32];
            end
            txn(rd_i, $urandom, 4'($urandom), dreg, int'($urandom % 6), 0,
                ($urandom % 4) == 0, $urandom);
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule